// File: doc/BRIEF.md
# Rotate-and-Masked-Insert Unit

This block is a 32-bit bit-field datapath. It takes a source word, rotates it left by a 5-bit amount, and builds a contiguous mask from a pair of 5-bit start and stop positions. It then merges the rotated bits that fall under the mask into a destination word. Every destination bit outside the mask passes through unchanged. A single instruction can therefore copy a field from any position in one word into any position in another. The mask may wrap past the end of the word and leave two runs of ones. A second mode skips the merge and returns the rotated source ANDed with the mask.

Each operation reads three values (source, destination and the rotate/mask specification) and writes one. One register stage sits between the operands and the result. A pulse on `in_valid` presents an operation. The result and `out_valid` appear on the next rising clock edge. Instruction decode, register access and hazard handling belong to the surrounding pipeline.

Top module: `rotmask_insert_unit`

## Requirements
- R1: One cycle after a rising clock edge at which `in_valid` is 1, `out_valid` is 1 and `out_result` carries that operation's result. After an edge at which `in_valid` is 0, `out_valid` is 0.
- R2: The source is rotated left by `in_rot`, not shifted. Source bit i lands at bit (i + `in_rot`) mod 32, so bits that leave the top re-enter at the bottom.
- R3: Mask positions count from the most significant end: position p is word bit 31-p. When `in_mbeg` <= `in_mend`, positions `in_mbeg` through `in_mend` inclusive are set. When `in_mbeg` == `in_mend`, exactly one bit is set.
- R4: When `in_mbeg` > `in_mend`, the mask wraps. Positions `in_mbeg`..31 and 0..`in_mend` are set, which gives two runs of ones.
- R5: When `in_mbeg` equals (`in_mend` + 1) mod 32, the mask is all ones.
- R6: With `in_mode` = 0 (merge), the result is (dst AND NOT mask) OR (rotated source AND mask). Every bit outside the mask equals the destination bit.
- R7: With `in_mode` = 1 (and-mask), the result is rotated source AND mask. The destination operand has no effect on the result.
- R8: While `in_valid` is 0, `out_result` holds its last value whatever the operand inputs do.
- R9: A synchronous active-high `rst` clears `out_valid` and `out_result` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_mode | input | 1 | 0 = merge into destination, 1 = and-with-mask |
| in_src | input | 32 | Source word to rotate |
| in_dst | input | 32 | Destination word to merge into |
| in_rot | input | 5 | Left-rotate amount |
| in_mbeg | input | 5 | Mask start position (MSB-first) |
| in_mend | input | 5 | Mask stop position (MSB-first) |
| out_valid | output | 1 | Result valid |
| out_result | output | 32 | Registered result |

## Verification
Each result is due exactly one rising edge after the edge that captures its operands, because one register separates the operands from `out_result`. The bench drives operands on a falling edge and samples on the next falling edge. That places each check half a period after the capturing edge and a half period before inputs can change again. The hold checks let several idle edges pass with the operands changing, and then compare the output against the last captured value.

// File: rtl/rmi_pkg.sv
package rmi_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned POS_W  = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [POS_W-1:0]  pos_t;

    typedef enum logic {
        MODE_MERGE = 1'b0,
        MODE_AND   = 1'b1
    } rmi_mode_e;

    typedef struct packed {
        rmi_mode_e mode;
        word_t     src;
        word_t     dst;
        pos_t      rot;
        pos_t      mbeg;
        pos_t      mend;
    } rmi_req_t;

    typedef struct packed {
        logic  valid;
        word_t result;
    } rmi_rsp_t;

    // Maps an MSB-first position onto a word bit index.
    function automatic pos_t pos_to_index(input pos_t p);
        return pos_t'(WORD_W - 1) - p;
    endfunction

endpackage

// File: rtl/rmi_rotl.sv
module rmi_rotl #(
    parameter int unsigned W  = rmi_pkg::WORD_W,
    parameter int unsigned SW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [SW-1:0] amt_i,
    output logic [W-1:0]  data_o
);
    logic [W-1:0] stage [SW+1];

    assign stage[0] = data_i;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int unsigned SH = 1 << k;
        logic [W-1:0] turned;
        assign turned       = {stage[k][W-1-SH:0], stage[k][W-1:W-SH]};
        assign stage[k+1]   = amt_i[k] ? turned : stage[k];
    end

    assign data_o = stage[SW];
endmodule

// File: rtl/rmi_mask_gen.sv
module rmi_mask_gen #(
    parameter int unsigned W  = rmi_pkg::WORD_W,
    parameter int unsigned PW = $clog2(W)
) (
    input  logic [PW-1:0] mbeg_i,
    input  logic [PW-1:0] mend_i,
    output logic [W-1:0]  mask_o
);
    logic wrap;
    assign wrap = mbeg_i > mend_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam logic [PW-1:0] POS = PW'(W - 1 - i);
        logic at_or_after_beg;
        logic at_or_before_end;
        assign at_or_after_beg  = POS >= mbeg_i;
        assign at_or_before_end = POS <= mend_i;
        assign mask_o[i] = wrap ? (at_or_after_beg | at_or_before_end)
                                : (at_or_after_beg & at_or_before_end);
    end
endmodule

// File: rtl/rmi_merge.sv
module rmi_merge #(
    parameter int unsigned W = rmi_pkg::WORD_W
) (
    input  rmi_pkg::rmi_mode_e mode_i,
    input  logic [W-1:0]       dst_i,
    input  logic [W-1:0]       rot_i,
    input  logic [W-1:0]       mask_i,
    output logic [W-1:0]       res_o
);
    logic [W-1:0] picked;
    logic [W-1:0] kept;

    always_comb begin
        picked = rot_i & mask_i;
        kept   = dst_i & ~mask_i;
        unique case (mode_i)
            rmi_pkg::MODE_AND: res_o = picked;
            default:           res_o = kept | picked;
        endcase
    end
endmodule

// File: rtl/rotmask_insert_unit.sv
module rotmask_insert_unit (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           in_valid,
    input  logic                           in_mode,
    input  logic [rmi_pkg::WORD_W-1:0]     in_src,
    input  logic [rmi_pkg::WORD_W-1:0]     in_dst,
    input  logic [rmi_pkg::POS_W-1:0]      in_rot,
    input  logic [rmi_pkg::POS_W-1:0]      in_mbeg,
    input  logic [rmi_pkg::POS_W-1:0]      in_mend,
    output logic                           out_valid,
    output logic [rmi_pkg::WORD_W-1:0]     out_result
);
    import rmi_pkg::*;

    rmi_req_t req;
    rmi_rsp_t rsp_q;
    word_t    rotated;
    word_t    mask;
    word_t    merged;

    always_comb begin
        req.mode = rmi_mode_e'(in_mode);
        req.src  = in_src;
        req.dst  = in_dst;
        req.rot  = in_rot;
        req.mbeg = in_mbeg;
        req.mend = in_mend;
    end

    rmi_rotl #(.W(WORD_W), .SW(POS_W)) u_rotl (
        .data_i (req.src),
        .amt_i  (req.rot),
        .data_o (rotated)
    );

    rmi_mask_gen #(.W(WORD_W), .PW(POS_W)) u_mask (
        .mbeg_i (req.mbeg),
        .mend_i (req.mend),
        .mask_o (mask)
    );

    rmi_merge #(.W(WORD_W)) u_merge (
        .mode_i (req.mode),
        .dst_i  (req.dst),
        .rot_i  (rotated),
        .mask_i (mask),
        .res_o  (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid <= in_valid;
            if (in_valid) begin
                rsp_q.result <= merged;
            end
        end
    end

    assign out_valid  = rsp_q.valid;
    assign out_result = rsp_q.result;
endmodule

// File: rtl/rmi_chk.sv
module rmi_chk (
    input logic                       clk,
    input logic                       rst,
    input logic                       in_valid,
    input logic                       in_mode,
    input logic [rmi_pkg::WORD_W-1:0] in_src,
    input logic [rmi_pkg::WORD_W-1:0] in_dst,
    input logic [rmi_pkg::POS_W-1:0]  in_rot,
    input logic [rmi_pkg::POS_W-1:0]  in_mbeg,
    input logic [rmi_pkg::POS_W-1:0]  in_mend,
    input logic                       out_valid,
    input logic [rmi_pkg::WORD_W-1:0] out_result
);
    localparam int unsigned W = rmi_pkg::WORD_W;

    logic [2*W-1:0] dbl;
    logic [W-1:0]   rot_ref;
    int unsigned    run_len;
    logic           full_span;

    assign dbl       = {in_src, in_src} << in_rot;
    assign rot_ref   = dbl[2*W-1:W];
    assign run_len   = (in_mbeg <= in_mend) ? (32'(in_mend) - 32'(in_mbeg) + 1)
                                            : (W - 32'(in_mbeg) + 32'(in_mend) + 1);
    assign full_span = (in_mbeg == in_mend + 1'b1);

    // R1
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_result)));

    // R5
    full_mask_rot_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode && full_span) |=> (out_result == $past(rot_ref)));

    // R7
    and_subset_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode) |=> ((out_result & ~$past(rot_ref)) == '0));

    // R6
    merge_only_diff_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_mode) |=>
        (((out_result ^ $past(in_dst)) & ~($past(rot_ref) ^ $past(in_dst))) == '0));

    // R3
    run_width_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode && (in_src == '1)) |=>
        ($countones(out_result) == $past(run_len)));
endmodule

bind rotmask_insert_unit rmi_chk u_chk (.*);

// File: tb/rotmask_insert_unit_test.sv
`timescale 1ns/1ps
module rotmask_insert_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_mode;
    logic [31:0] in_src;
    logic [31:0] in_dst;
    logic [4:0]  in_rot;
    logic [4:0]  in_mbeg;
    logic [4:0]  in_mend;
    logic        out_valid;
    logic [31:0] out_result;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rotmask_insert_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_src(in_src), .in_dst(in_dst), .in_rot(in_rot),
        .in_mbeg(in_mbeg), .in_mend(in_mend),
        .out_valid(out_valid), .out_result(out_result)
    );

    function automatic logic [31:0] ref_rotl(input logic [31:0] w, input int r);
        logic [31:0] res = '0;
        for (int i = 0; i < 32; i++) res[(i + r) % 32] = w[i];
        return res;
    endfunction

    // Walks positions from start to stop, wrapping; position p is bit 31-p.
    function automatic logic [31:0] ref_mask(input int b, input int e);
        logic [31:0] m = '0;
        int p = b;
        for (int n = 0; n < 32; n++) begin
            m[31 - p] = 1'b1;
            if (p == e) break;
            p = (p + 1) % 32;
        end
        return m;
    endfunction

    function automatic logic [31:0] ref_op(input logic md, input logic [31:0] s,
                                           input logic [31:0] d, input int r,
                                           input int b, input int e);
        logic [31:0] rt = ref_rotl(s, r);
        logic [31:0] mk = ref_mask(b, e);
        return md ? (rt & mk) : ((d & ~mk) | (rt & mk));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drives one operation on a falling edge, checks it one edge later.
    task automatic run_op(input string tag, input logic md, input logic [31:0] s,
                          input logic [31:0] d, input int r, input int b, input int e);
        @(negedge clk);
        in_valid = 1'b1; in_mode = md; in_src = s; in_dst = d;
        in_rot = 5'(r); in_mbeg = 5'(b); in_mend = 5'(e);
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R1 valid"}, {31'b0, out_valid}, 32'd1);
        check(tag, out_result, ref_op(md, s, d, r, b, e));
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0; in_mode = 1'b0;
        in_src = '0; in_dst = '0; in_rot = '0; in_mbeg = '0; in_mend = '0;
        repeat (3) @(negedge clk);
        check("R9 reset valid", {31'b0, out_valid}, 32'd0);
        check("R9 reset result", out_result, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_rotate;
        run_op("R2 rotate wrap-in", 1'b1, 32'h8000_0001, 32'h0, 1, 0, 31);
        run_op("R2 rotate by 31", 1'b1, 32'h0000_0001, 32'h0, 31, 0, 31);
        run_op("R2 rotate by 0", 1'b1, 32'hDEAD_BEEF, 32'h0, 0, 0, 31);
        check("R2 direct", out_result, 32'hDEAD_BEEF);
        run_op("R2 rotate by 4", 1'b1, 32'h1234_5678, 32'h0, 4, 0, 31);
        check("R2 direct rot4", out_result, 32'h2345_6781);
    endtask

    task automatic t_single_bit;
        run_op("R3 single msb", 1'b1, 32'hFFFF_FFFF, 32'h0, 0, 0, 0);
        check("R3 single msb direct", out_result, 32'h8000_0000);
        run_op("R3 single lsb", 1'b1, 32'hFFFF_FFFF, 32'h0, 0, 31, 31);
        check("R3 single lsb direct", out_result, 32'h0000_0001);
    endtask

    task automatic t_wrap;
        run_op("R4 split mask", 1'b1, 32'hFFFF_FFFF, 32'h0, 0, 28, 3);
        check("R4 split direct", out_result, 32'hF000_000F);
        run_op("R4 split merge", 1'b0, 32'h0, 32'hFFFF_FFFF, 0, 30, 1);
        check("R4 split merge direct", out_result, 32'h3FFF_FFFC);
    endtask

    task automatic t_full;
        run_op("R5 full b=0 e=31", 1'b0, 32'hA5A5_0F0F, 32'h1234_5678, 8, 0, 31);
        run_op("R5 full b=13 e=12", 1'b0, 32'hCAFE_F00D, 32'h0, 3, 13, 12);
        check("R5 full direct", out_result, ref_rotl(32'hCAFE_F00D, 3));
    endtask

    task automatic t_field_insert;
        // bits [30:21] of src moved to bits [10:1] of dst
        run_op("R6 field insert", 1'b0, 32'h7FE0_0000, 32'h8000_0801, 12, 21, 30);
        check("R6 field insert direct", out_result, 32'h8000_0FFF);
    endtask

    task automatic t_and_ignores_dst;
        logic [31:0] first;
        run_op("R7 dst zero", 1'b1, 32'h0F0F_3C3C, 32'h0, 5, 4, 20);
        first = out_result;
        run_op("R7 dst ones", 1'b1, 32'h0F0F_3C3C, 32'hFFFF_FFFF, 5, 4, 20);
        check("R7 dst ignored", out_result, first);
    endtask

    task automatic t_hold;
        logic [31:0] held;
        run_op("R8 setup", 1'b0, 32'h1357_9BDF, 32'h2468_ACE0, 7, 9, 2);
        held = out_result;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_src = 32'(k * 32'h1111_1111); in_dst = ~in_src;
            in_rot = 5'(k + 3); in_mode = k[0];
        end
        check("R8 hold valid", {31'b0, out_valid}, 32'd0);
        check("R8 hold result", out_result, held);
    endtask

    task automatic t_sweep;
        for (int b = 0; b < 32; b++) begin
            for (int e = 0; e < 32; e++) begin
                logic [31:0] s = $urandom;
                logic [31:0] d = $urandom;
                int r = $urandom_range(0, 31);
                run_op((b > e) ? "R4 sweep" : "R3 sweep", 1'(e & 1), s, d, r, b, e);
            end
        end
    endtask

    task automatic t_midreset;
        run_op("R9 pre", 1'b1, 32'hFFFF_FFFF, 32'h0, 0, 0, 31);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        check("R9 mid valid", {31'b0, out_valid}, 32'd0);
        check("R9 mid result", out_result, 32'd0);
        rst = 1'b0; in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_rotate();
        t_single_bit();
        t_wrap();
        t_full();
        t_field_insert();
        t_and_ignores_dst();
        t_hold();
        t_sweep();
        t_midreset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule